// File: doc/BRIEF.md
# Programmable-Window Packet CRC Checker

This block watches a received packet as it streams past, one byte per clock, and runs a 32-bit CRC over a byte range chosen by software. When the packet ends it compares the CRC it computed with the CRC field carried inside the packet, and it reports a single status bit that says whether the two agree. The status bit can instead carry an externally supplied TCP checksum result, so that one descriptor bit can report either check.

Software programs the block before the packet starts. It sets the first and last byte of the range, the byte offset of the CRC field, which of two polynomial registers to use, whether each byte is bit-reversed, whether the result is inverted before the compare, and whether the range ends implicitly one byte before the end of the packet (the FCoE-style mode). All of these settings are captured on the start-of-packet byte. Later changes take effect from the next packet.

Top module: `pkt_crc_checker`

## Requirements
- R1: The byte that carries in_sop with in_valid high has offset 0, and each later byte with in_valid high adds one to the offset. Cycles with in_valid low are ignored. Bytes with in_valid high that arrive while no packet is open and that lack in_sop are ignored and produce no status.
- R2: The CRC register is preset to all ones at start-of-packet and is updated MSB-first, eight bits per byte. The update uses cfg_poly1 when cfg_poly_sel is 1 and cfg_poly0 when it is 0.
- R3: With cfg_fcoe = 0, the bytes at offsets cfg_start through cfg_end, both included, enter the CRC. The range closes at the byte whose offset equals cfg_end.
- R4: With cfg_fcoe = 1, the bytes from offset cfg_start up to but not including the end-of-packet byte enter the CRC. The range closes at end-of-packet if that byte's offset is greater than cfg_start. In this mode the CRC field is never zeroed.
- R5: With cfg_fcoe = 0, if cfg_crc_pos lies between cfg_start and cfg_end (both included), the in-range bytes at offsets cfg_crc_pos to cfg_crc_pos+3 enter the CRC as zero.
- R6: When cfg_mirror = 1, the bit order of each byte is reversed (bit 0 becomes bit 7) before the byte enters the CRC.
- R7: When cfg_invert = 1, the computed CRC is bit-inverted before the compare.
- R8: The received CRC is made of the four raw bytes at offsets cfg_crc_pos to cfg_crc_pos+3, with the first byte as the most significant. With cfg_use_crc = 1, stat_ok is 1 only if the range has closed, all four bytes have been seen, and the final CRC equals the received CRC.
- R9: A packet that ends before its range closes reports stat_ok = 0 when cfg_use_crc = 1.
- R10: When cfg_use_crc = 0, stat_ok equals the tcp_csum_ok input as sampled on the end-of-packet byte.
- R11: stat_valid is high for exactly one cycle, in the cycle after each accepted end-of-packet byte, and at no other time.
- R12: All cfg_* inputs, including both polynomials, are sampled on the start-of-packet byte. Changes made during a packet do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte qualifier |
| in_sop | input | 1 | First byte of packet |
| in_eop | input | 1 | Last byte of packet |
| in_data | input | 8 | Packet byte |
| cfg_start | input | 8 | First offset in the CRC range |
| cfg_end | input | 16 | Last offset in the range (cfg_fcoe = 0) |
| cfg_crc_pos | input | 16 | Offset of the first CRC field byte |
| cfg_poly_sel | input | 1 | 1: cfg_poly1, 0: cfg_poly0 |
| cfg_poly0 | input | 32 | Polynomial register 0 |
| cfg_poly1 | input | 32 | Polynomial register 1 |
| cfg_mirror | input | 1 | Reverse the bits of each byte |
| cfg_invert | input | 1 | Invert the final CRC |
| cfg_fcoe | input | 1 | Range ends before the last byte |
| cfg_use_crc | input | 1 | 1: report the CRC result, 0: report tcp_csum_ok |
| tcp_csum_ok | input | 1 | External TCP checksum status |
| stat_valid | output | 1 | Status pulse |
| stat_ok | output | 1 | Pass (1) or fail (0) |

## Verification
The assertions check the framing of the status on every cycle. Each accepted end-of-packet byte is followed by one status pulse, and no pulse appears without one. The checksum pass-through, the forced fail when the range has not closed, the holding of the captured configuration within a packet, and the silence after stray bytes are checked the same way. Whether the CRC value itself is right can only be shown by the bench scenarios. They compare the result against a reference model under both polynomials, mirroring, inversion, zeroing of the field inside the range, the FCoE-style end, and configuration changes made during a packet.

// File: rtl/crcchk_pkg.sv
package crcchk_pkg;
  localparam int CRC_W   = 32;
  localparam int OFF_W   = 16;
  localparam int START_W = 8;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic [START_W-1:0] start;
    logic [OFF_W-1:0]   end_off;
    logic [OFF_W-1:0]   pos;
    logic               poly_sel;
    logic [CRC_W-1:0]   poly0;
    logic [CRC_W-1:0]   poly1;
    logic               mirror;
    logic               invert;
    logic               fcoe;
    logic               use_crc;
  } cfg_t;
endpackage

// File: rtl/crcchk_step.sv
module crcchk_step #(
  parameter int W  = 32,
  parameter int BW = 8
) (
  input  logic [W-1:0]  crc_in,
  input  logic [BW-1:0] data,
  input  logic [W-1:0]  poly,
  input  logic          mirror,
  output logic [W-1:0]  crc_out
);
  logic [BW-1:0] rev;
  logic [BW-1:0] dat;

  for (genvar k = 0; k < BW; k++) begin : g_rev
    assign rev[k] = data[BW-1-k];
  end

  assign dat = mirror ? rev : data;

  always_comb begin
    logic [W-1:0] c;
    logic         fb;
    c = crc_in;
    for (int i = BW - 1; i >= 0; i--) begin
      fb = c[W-1] ^ dat[i];
      c  = {c[W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    crc_out = c;
  end
endmodule

// File: rtl/crcchk_window.sv
module crcchk_window
  import crcchk_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  input  cfg_t             cfg,
  input  logic             last,
  output logic             in_win,
  output logic             zero_byte,
  output logic             cap_en,
  output logic             cap_last,
  output logic             close_now
);
  logic [OFF_W:0] off_x;
  logic [OFF_W:0] pos_x;
  logic [OFF_W:0] pos_end;
  logic [OFF_W:0] start_x;
  logic [OFF_W:0] end_x;
  logic           pos_inside;

  assign off_x   = {1'b0, off};
  assign pos_x   = {1'b0, cfg.pos};
  assign pos_end = pos_x + (OFF_W+1)'(3);
  assign start_x = (OFF_W+1)'(cfg.start);
  assign end_x   = {1'b0, cfg.end_off};

  assign pos_inside = (pos_x >= start_x) && (pos_x <= end_x);

  always_comb begin
    if (cfg.fcoe) begin
      in_win    = (off_x >= start_x) && !last;
      close_now = last && (off_x > start_x);
      zero_byte = 1'b0;
    end else begin
      in_win    = (off_x >= start_x) && (off_x <= end_x);
      close_now = (off_x == end_x);
      zero_byte = pos_inside && (off_x >= pos_x) && (off_x <= pos_end) && in_win;
    end
  end

  assign cap_en   = (off_x >= pos_x) && (off_x <= pos_end);
  assign cap_last = (off_x == pos_end);
endmodule

// File: rtl/pkt_crc_checker.sv
module pkt_crc_checker
  import crcchk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic                 in_eop,
  input  logic [BYTE_W-1:0]    in_data,
  input  logic [START_W-1:0]   cfg_start,
  input  logic [OFF_W-1:0]     cfg_end,
  input  logic [OFF_W-1:0]     cfg_crc_pos,
  input  logic                 cfg_poly_sel,
  input  logic [CRC_W-1:0]     cfg_poly0,
  input  logic [CRC_W-1:0]     cfg_poly1,
  input  logic                 cfg_mirror,
  input  logic                 cfg_invert,
  input  logic                 cfg_fcoe,
  input  logic                 cfg_use_crc,
  input  logic                 tcp_csum_ok,
  output logic                 stat_valid,
  output logic                 stat_ok
);
  cfg_t cfg_in, cfg_q, cfg_eff;

  logic              in_pkt_q, in_pkt_d;
  logic [OFF_W-1:0]  off_q, off_d, off_cur;
  logic [CRC_W-1:0]  crc_q, crc_d, crc_cur, crc_step, crc_fin;
  logic [CRC_W-1:0]  rx_q, rx_d, rx_cur;
  logic              done_q, done_d, done_cur;
  logic              got_q, got_d, got_cur;
  logic              stat_valid_q, stat_valid_d;
  logic              stat_ok_q, stat_ok_d;

  logic              pkt_start, accept, pkt_end;
  logic              in_win, zero_byte, cap_en, cap_last, close_now;
  logic [BYTE_W-1:0] byte_in;
  logic [CRC_W-1:0]  poly;

  assign cfg_in = '{start: cfg_start, end_off: cfg_end, pos: cfg_crc_pos,
                    poly_sel: cfg_poly_sel, poly0: cfg_poly0, poly1: cfg_poly1,
                    mirror: cfg_mirror, invert: cfg_invert, fcoe: cfg_fcoe,
                    use_crc: cfg_use_crc};

  assign pkt_start = in_valid && in_sop;
  assign accept    = in_valid && (in_sop || in_pkt_q);
  assign pkt_end   = accept && in_eop;

  assign cfg_eff  = pkt_start ? cfg_in : cfg_q;
  assign off_cur  = pkt_start ? '0 : off_q;
  assign crc_cur  = pkt_start ? '1 : crc_q;
  assign rx_cur   = pkt_start ? '0 : rx_q;
  assign done_cur = pkt_start ? 1'b0 : done_q;
  assign got_cur  = pkt_start ? 1'b0 : got_q;

  crcchk_window u_win (
    .off       (off_cur),
    .cfg       (cfg_eff),
    .last      (in_eop),
    .in_win    (in_win),
    .zero_byte (zero_byte),
    .cap_en    (cap_en),
    .cap_last  (cap_last),
    .close_now (close_now)
  );

  assign byte_in = zero_byte ? '0 : in_data;
  assign poly    = cfg_eff.poly_sel ? cfg_eff.poly1 : cfg_eff.poly0;

  crcchk_step #(.W(CRC_W), .BW(BYTE_W)) u_step (
    .crc_in  (crc_cur),
    .data    (byte_in),
    .poly    (poly),
    .mirror  (cfg_eff.mirror),
    .crc_out (crc_step)
  );

  always_comb begin
    in_pkt_d     = in_pkt_q;
    if (pkt_start) in_pkt_d = 1'b1;
    if (pkt_end)   in_pkt_d = 1'b0;
    off_d        = (&off_cur) ? off_cur : off_cur + 1'b1;
    crc_d        = in_win ? crc_step : crc_cur;
    rx_d         = cap_en ? {rx_cur[CRC_W-BYTE_W-1:0], in_data} : rx_cur;
    done_d       = done_cur | close_now;
    got_d        = got_cur | (cap_en && cap_last);
    crc_fin      = cfg_eff.invert ? ~crc_d : crc_d;
    stat_valid_d = pkt_end;
    if (!pkt_end)
      stat_ok_d = 1'b0;
    else if (cfg_eff.use_crc)
      stat_ok_d = done_d && got_d && (crc_fin == rx_d);
    else
      stat_ok_d = tcp_csum_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (pkt_start) begin
      cfg_q <= cfg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      off_q    <= '0;
      crc_q    <= '1;
      rx_q     <= '0;
      done_q   <= 1'b0;
      got_q    <= 1'b0;
    end else if (accept) begin
      in_pkt_q <= in_pkt_d;
      off_q    <= off_d;
      crc_q    <= crc_d;
      rx_q     <= rx_d;
      done_q   <= done_d;
      got_q    <= got_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid_q <= 1'b0;
      stat_ok_q    <= 1'b0;
    end else begin
      stat_valid_q <= stat_valid_d;
      stat_ok_q    <= stat_ok_d;
    end
  end

  assign stat_valid = stat_valid_q;
  assign stat_ok    = stat_ok_q;

  AST_STAT_NEEDS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(in_valid && in_eop && (in_sop || in_pkt_q))); // R11
  AST_EOP_GIVES_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eop && (in_sop || in_pkt_q)) |=> stat_valid); // R11
  AST_TCP_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !cfg_eff.use_crc) |=> (stat_ok == $past(tcp_csum_ok))); // R10
  AST_OPEN_WINDOW_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && cfg_eff.use_crc && !done_d) |=> !stat_ok); // R9
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_sop) |=> $stable(cfg_q)); // R12
  AST_STRAY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sop && !in_pkt_q) |=> !stat_valid); // R1
endmodule

// File: tb/pkt_crc_checker_bench.sv
`timescale 1ns/1ps
module pkt_crc_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop;
  logic [7:0]  in_data;
  logic [7:0]  b_start;
  logic [15:0] b_end, b_pos;
  logic        b_psel, b_mir, b_inv, b_fcoe, b_use, b_tcp;
  logic [31:0] b_poly0, b_poly1;
  logic        stat_valid, stat_ok;

  int n_checks = 0;
  int n_fail   = 0;
  int n_stray  = 0;
  logic [7:0] pkt [0:63];
  bit    exp_q [$];
  string tag_q [$];

  always #4 clk = ~clk;

  pkt_crc_checker u_pkt_crc_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .cfg_start(b_start), .cfg_end(b_end),
    .cfg_crc_pos(b_pos), .cfg_poly_sel(b_psel), .cfg_poly0(b_poly0),
    .cfg_poly1(b_poly1), .cfg_mirror(b_mir), .cfg_invert(b_inv),
    .cfg_fcoe(b_fcoe), .cfg_use_crc(b_use), .tcp_csum_ok(b_tcp),
    .stat_valid(stat_valid), .stat_ok(stat_ok));

  task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] b);
    logic [7:0]  d;
    logic [31:0] p;
    p = b_psel ? b_poly1 : b_poly0;
    for (int k = 0; k < 8; k++) d[k] = b_mir ? b[7-k] : b[k];
    for (int k = 7; k >= 0; k--) begin
      if (c[31] ^ d[k]) c = (c << 1) ^ p;
      else              c = c << 1;
    end
    return c;
  endfunction

  // reference: returns final CRC, received CRC, done and got flags
  task automatic ref_run(input int len, output logic [31:0] fin,
                         output logic [31:0] rx, output bit done, output bit got);
    logic [31:0] c;
    bit last, win, zero;
    c = '1; rx = '0; done = 0; got = 0;
    for (int o = 0; o < len; o++) begin
      last = (o == len - 1);
      if (b_fcoe) begin
        win = (o >= b_start) && !last;
        if (last && o > b_start) done = 1;
        zero = 0;
      end else begin
        win = (o >= b_start) && (o <= b_end);
        if (o == b_end) done = 1;
        zero = (b_pos >= b_start) && (b_pos <= b_end) && (o >= b_pos) && (o <= b_pos + 3);
      end
      if (win) c = ref_step(c, zero ? 8'h00 : pkt[o]);
      if (o >= b_pos && o <= b_pos + 3) begin
        rx = {rx[23:0], pkt[o]};
        if (o == b_pos + 3) got = 1;
      end
    end
    fin = b_inv ? ~c : c;
  endtask

  task automatic fill(input int len, input int seed);
    for (int i = 0; i < len; i++) pkt[i] = 8'((i * 37 + seed * 11 + 5) & 8'hff);
  endtask

  task automatic insert_crc(input int len);
    logic [31:0] f, r;
    bit d, g;
    ref_run(len, f, r, d, g);
    for (int i = 0; i < 4; i++) pkt[b_pos + i] = f[31 - 8*i -: 8];
  endtask

  task automatic send(input int len, input string tag, input bit flip);
    logic [31:0] f, r;
    bit d, g, e;
    ref_run(len, f, r, d, g);
    e = b_use ? (d && g && f == r) : b_tcp;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int o = 0; o < len; o++) begin
      if (o == 3) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (o == 0);
      in_eop   = (o == len - 1);
      in_data  = pkt[o];
      if (flip && o == 1) begin
        b_psel = ~b_psel; b_inv = ~b_inv; b_mir = ~b_mir;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    chk(stat_valid == 1'b1, "R11 status pulse one cycle after eop", 32'(stat_valid), 1);
    if (flip) begin
      b_psel = ~b_psel; b_inv = ~b_inv; b_mir = ~b_mir;
    end
    @(negedge clk);
    chk(stat_valid == 1'b0, "R11 status lasts one cycle", 32'(stat_valid), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && stat_valid) begin
      if (exp_q.size() == 0) begin
        n_stray++;
        chk(1'b0, "R11 unexpected status", 32'(stat_ok), 0);
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(stat_ok == e, t, 32'(stat_ok), 32'(e));
      end
    end
  end

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int s;
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    b_start = 8'd2; b_end = 16'd13; b_pos = 16'd14; b_psel = 1'b0;
    b_poly0 = 32'h04C11DB7; b_poly1 = 32'h1EDC6F41;
    b_mir = 1'b0; b_inv = 1'b0; b_fcoe = 1'b0; b_use = 1'b1; b_tcp = 1'b0;
    repeat (3) @(negedge clk);
    chk(stat_valid == 1'b0 && stat_ok == 1'b0, "R11 reset state", 32'({stat_valid, stat_ok}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R8: poly0, range 2..13, field at 14 outside range
    fill(18, 1); insert_crc(18);
    send(18, "R3 plain range pass", 0);
    pkt[5] = pkt[5] ^ 8'h10;
    send(18, "R8 corrupted byte fails", 0);

    // R2: polynomial register 1
    b_psel = 1'b1; fill(18, 2); insert_crc(18);
    send(18, "R2 poly1 pass", 0);
    b_psel = 1'b0;
    send(18, "R2 poly0 on poly1 packet fails", 0);

    // R6 R7: mirroring and inversion
    b_mir = 1'b1; b_inv = 1'b1; fill(18, 3); insert_crc(18);
    send(18, "R6 mirrored pass", 0);
    b_inv = 1'b0;
    send(18, "R7 inversion off fails", 0);
    b_inv = 1'b1; b_mir = 1'b0;
    send(18, "R6 mirror off fails", 0);
    b_mir = 1'b0; b_inv = 1'b0;

    // R5: field inside the range is zeroed
    b_start = 8'd0; b_end = 16'd19; b_pos = 16'd8;
    fill(20, 4); insert_crc(20);
    send(20, "R5 in-range field zeroed pass", 0);

    // R4: FCoE-style end, field ahead of range
    b_fcoe = 1'b1; b_start = 8'd6; b_pos = 16'd0; b_end = 16'd3;
    fill(16, 5); insert_crc(16);
    send(16, "R4 fcoe pass", 0);
    pkt[15] = pkt[15] ^ 8'hA5;
    send(16, "R4 last byte excluded", 0);
    pkt[10] = pkt[10] ^ 8'h01;
    send(16, "R4 in-range byte change fails", 0);
    b_fcoe = 1'b0;

    // R9: packet ends before the range closes
    b_start = 8'd2; b_end = 16'd30; b_pos = 16'd14;
    fill(20, 6); insert_crc(20);
    send(20, "R9 early end fails", 0);

    // R10: checksum pass-through
    b_end = 16'd13; b_use = 1'b0; b_tcp = 1'b1;
    fill(18, 7);
    send(18, "R10 tcp status 1 passed through", 0);
    insert_crc(18); b_tcp = 1'b0;
    send(18, "R10 tcp status 0 passed through", 0);
    b_use = 1'b1;

    // R12: configuration changed in mid-packet
    fill(18, 8); insert_crc(18);
    send(18, "R12 mid-packet cfg change ignored", 1);

    // R1: stray bytes with no open packet
    s = n_stray;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == 2); in_data = 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_stray == s && stat_valid == 1'b0, "R1 stray bytes give no status", 32'(n_stray - s), 0);
    fill(18, 9); insert_crc(18);
    send(18, "R1 packet after stray bytes pass", 0);

    // R11: one-byte packet
    fill(1, 10);
    send(1, "R11 single-byte packet", 0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 every packet reported", 32'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule